// File: doc/BRIEF.md
# Tracking Angle Counter with Frozen-Read Output Latch

This block holds the digital angle of a tracking converter. An external rate generator issues count-up and count-down request pulses, and the block moves a 16-bit angle word up or down by one least significant step of the resolution now selected. A two-bit select picks 10, 12, 14 or 16 bits of resolution. At the coarser settings the unused low bits are held at zero, and each step has a larger weight.

The angle passes through a transparent output latch. An active-low hold input freezes the latch for a read while the counter goes on tracking. The latched word is read out over an 8-bit tri-state bus in two bytes, and each byte has its own active-low enable. Every counter update raises a busy pulse of programmable length. A direction flag shows which way the last step went. Requests that arrive while a pulse is active are queued, at most one per direction.

Top module: `angle_track_counter`

## Requirements
- R1: The resolution select `res_sel` chooses the angle width: 2'b00 is 10 bits, 2'b01 is 12 bits, 2'b10 is 14 bits and 2'b11 is 16 bits. One accepted step changes the angle by 2^(16-bits) (64, 16, 4 or 1), modulo 2^16.
- R2: At a resolution of N bits, the low 16-N bits of the counted angle and of `angle_word` are always zero.
- R3: The angle wraps modulo 2^16 in both directions. One up step from full scale minus one step gives zero, and one down step from zero gives 2^16 minus one step.
- R4: While `hold_n` is low at a clock edge, `angle_word` and the bus data keep their value while the counter keeps counting. At the first edge with `hold_n` high, `angle_word` shows the current count.
- R5: `data_bus` carries `angle_word[15:8]` while `hi_en_n` is low and `angle_word[7:0]` while only `lo_en_n` is low. When both enables are high it is high impedance. The high byte wins when both are low.
- R6: On the clock edge that accepts a step, the counter and (when not held) `angle_word` update, and `busy` rises. `busy` stays high for exactly BUSY_CYC cycles, then is low for at least one cycle before the next step.
- R7: `dir_up` becomes 1 on an accepted up step and 0 on an accepted down step. It holds its value when no step is accepted. It is 1 after reset.
- R8: Requests made while `busy` is high are queued, at most one per direction, and served after the pulse ends. Many up requests within one pulse give one extra step.
- R9: When an up and a down request are both pending at an accept point, the up step is taken first and the down step is served at the next accept point.
- R10: After a change of `res_sel`, the next clock edge truncates the held angle to the new step weight by clearing the now-unused low bits.
- R11: Synchronous active-high reset clears the angle to zero, clears `busy` and the queue, and sets `dir_up` to 1.

Ports are listed in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Count-up request |
| dn_req | input | 1 | Count-down request |
| res_sel | input | 2 | Resolution select |
| hold_n | input | 1 | Output latch freeze, active low |
| hi_en_n | input | 1 | High-byte read enable, active low |
| lo_en_n | input | 1 | Low-byte read enable, active low |
| data_bus | output | 8 | Tri-state byte read bus |
| angle_word | output | 16 | Latched, masked angle |
| busy | output | 1 | Pulse for each counter update |
| dir_up | output | 1 | Direction of the last step |

## Verification
A wrong count value shows on `angle_word` at the negative edge just after the busy pulse rises. A broken wrap shows at the first step across zero in either direction. A fault in the queue or the arbitration shows as a missing or extra step once the busy pulse that covered the requests has ended. A wrong mask or missed truncation shows one cycle after a resolution change, as nonzero low bits. A latch that ignores the hold input shows at once as a changed word during a frozen read, and a bad byte selection shows on the bus in the same cycle the enables change.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int RES_CODES = 4;

  // number of low bits forced to zero for a resolution code
  function automatic int unsigned drop_bits(input logic [1:0] sel);
    return 2 * (RES_CODES - 1 - int'(sel));
  endfunction
endpackage

// File: rtl/atc_arbiter.sv
module atc_arbiter #(
  parameter int BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic up_req,
  input  logic dn_req,
  output logic step_en,
  output logic step_up,
  output logic busy,
  output logic dir_up
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [BW-1:0] busy_cnt;
  logic          q_up, q_dn;
  logic          want_up, want_dn, idle;

  assign idle    = (busy_cnt == '0);
  assign want_up = q_up | up_req;
  assign want_dn = q_dn | dn_req;
  assign step_en = idle & (want_up | want_dn);
  assign step_up = want_up;
  assign busy    = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      q_up     <= 1'b0;
      q_dn     <= 1'b0;
      dir_up   <= 1'b1;
    end else begin
      if (idle) begin
        q_up <= 1'b0;
        q_dn <= want_up & want_dn;
        if (step_en) begin
          busy_cnt <= BW'(BUSY_CYC);
          dir_up   <= want_up;
        end
      end else begin
        busy_cnt <= busy_cnt - 1'b1;
        q_up     <= want_up;
        q_dn     <= want_dn;
      end
    end
  end

  assert_dir_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(dir_up));
  assert_no_step_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(step_en));
endmodule

// File: rtl/atc_counter.sv
module atc_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       res_sel,
  input  logic             step_en,
  input  logic             step_up,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] cnt_nxt
);
  import atc_pkg::*;

  logic [WIDTH-1:0] mask, weight, base;

  assign mask   = {WIDTH{1'b1}} << drop_bits(res_sel);
  assign weight = {{(WIDTH-1){1'b0}}, 1'b1} << drop_bits(res_sel);
  assign base   = cnt_q & mask;

  always_comb begin
    cnt_nxt = base;
    if (step_en) cnt_nxt = step_up ? base + weight : base - weight;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q & ~({WIDTH{1'b1}} << drop_bits($past(res_sel)))) == '0);
endmodule

// File: rtl/atc_out_latch.sv
module atc_out_latch #(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_n,
  input  logic [WIDTH-1:0]  din,
  input  logic              hi_en_n,
  input  logic              lo_en_n,
  output logic [WIDTH-1:0]  word_q,
  output logic [BYTE_W-1:0] bus
);
  always_ff @(posedge clk) begin
    if (rst)         word_q <= '0;
    else if (hold_n) word_q <= din;
  end

  assign bus = !hi_en_n ? word_q[WIDTH-1 -: BYTE_W] :
               !lo_en_n ? word_q[BYTE_W-1:0] : {BYTE_W{1'bz}};

  assert_frozen_word_R4: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> $stable(word_q));
endmodule

// File: rtl/angle_track_counter.sv
module angle_track_counter #(
  parameter int WIDTH    = 16,
  parameter int BYTE_W   = 8,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              dn_req,
  input  logic [1:0]        res_sel,
  input  logic              hold_n,
  input  logic              hi_en_n,
  input  logic              lo_en_n,
  output logic [BYTE_W-1:0] data_bus,
  output logic [WIDTH-1:0]  angle_word,
  output logic              busy,
  output logic              dir_up
);
  logic             step_en, step_up;
  logic [WIDTH-1:0] cnt_q, cnt_nxt;

  atc_arbiter #(.BUSY_CYC(BUSY_CYC)) u_arb (
    .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
    .step_en(step_en), .step_up(step_up), .busy(busy), .dir_up(dir_up)
  );

  atc_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .res_sel(res_sel), .step_en(step_en),
    .step_up(step_up), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  atc_out_latch #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_lat (
    .clk(clk), .rst(rst), .hold_n(hold_n), .din(cnt_nxt),
    .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .word_q(angle_word), .bus(data_bus)
  );

  // a count change with steady resolution only happens with a new busy pulse
  assert_count_with_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q) && $past(res_sel) == $past(res_sel, 2)) |-> $rose(busy));
  assert_latch_follows_R4: assert property (@(posedge clk) disable iff (rst)
    $past(hold_n) |-> angle_word == cnt_q);
endmodule

// File: tb/angle_track_counter_bench.sv
module angle_track_counter_bench;
  localparam int BUSY = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic up_req = 0, dn_req = 0, hold_n = 1, hi_en_n = 1, lo_en_n = 1;
  logic [1:0] res_sel = 2'b11;
  wire  [7:0] data_bus;
  logic [15:0] angle_word;
  logic busy, dir_up;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  angle_track_counter #(.WIDTH(16), .BYTE_W(8), .BUSY_CYC(BUSY)) u_angle_track_counter (
    .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req), .res_sel(res_sel),
    .hold_n(hold_n), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .data_bus(data_bus),
    .angle_word(angle_word), .busy(busy), .dir_up(dir_up)
  );

  function automatic logic [15:0] wt(input logic [1:0] s);
    return 16'd1 << (2 * (3 - s));
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // one request pulse; checks busy, direction and the count (R1 R6 R7)
  task automatic step(input bit up);
    @(negedge clk); up_req = up; dn_req = !up;
    @(negedge clk); up_req = 0; dn_req = 0;
    exp_cnt = up ? exp_cnt + wt(res_sel) : exp_cnt - wt(res_sel);
    chk("R6 busy rises", {15'd0, busy}, 16'd1);
    chk("R7 dir", {15'd0, dir_up}, {15'd0, up});
    if (hold_n) chk("R1 angle step", angle_word, exp_cnt);
    repeat (BUSY - 1) @(negedge clk);
    chk("R6 busy width", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R6 busy ends", {15'd0, busy}, 16'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] frozen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 angle", angle_word, 16'd0);
    chk("R11 busy", {15'd0, busy}, 16'd0);
    chk("R11 dir", {15'd0, dir_up}, 16'd1);

    // R1 R3: full sweep at 10 bits around the circle
    res_sel = 2'b00;
    for (int i = 0; i < 1024; i++) step(1);
    chk("R3 up wrap", angle_word, 16'd0);
    // R3 down wrap at every resolution
    for (int s = 0; s < 4; s++) begin
      res_sel = 2'(s);
      @(negedge clk);
      step(0);
      chk("R3 down wrap", angle_word, 16'h0000 - wt(2'(s)));
      step(1);
      chk("R3 back to zero", angle_word, 16'd0);
    end

    // R2 R10: build 0x0027 at 16 bits, then coarsen
    res_sel = 2'b11;
    for (int i = 0; i < 39; i++) step(1);
    chk("R1 16-bit value", angle_word, 16'h0027);
    res_sel = 2'b10; @(negedge clk); exp_cnt = 16'h0024;
    chk("R10 trunc 14", angle_word, 16'h0024);
    res_sel = 2'b01; @(negedge clk); exp_cnt = 16'h0020;
    chk("R10 trunc 12", angle_word, 16'h0020);
    res_sel = 2'b00; @(negedge clk); exp_cnt = 16'h0000;
    chk("R10 trunc 10", angle_word, 16'h0000);
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R2 low bits zero", angle_word & 16'h003F, 16'd0);
    end

    // R5 bus reads of 0x0140
    hi_en_n = 0; #1;
    chk("R5 high byte", {8'd0, data_bus}, {8'd0, angle_word[15:8]});
    lo_en_n = 0; #1;
    chk("R5 high wins", {8'd0, data_bus}, {8'd0, angle_word[15:8]});
    hi_en_n = 1; #1;
    chk("R5 low byte", {8'd0, data_bus}, {8'd0, angle_word[7:0]});
    lo_en_n = 1; #1;
    n_chk++;
    if (data_bus !== 8'hzz) begin
      n_fail++; $display("FAIL R5 hiZ actual %h expected zz", data_bus);
    end

    // R4 hold freezes output, counter keeps tracking
    res_sel = 2'b11; @(negedge clk);
    hold_n = 0; @(negedge clk);
    frozen = angle_word;
    for (int i = 0; i < 3; i++) step(1);
    chk("R4 frozen word", angle_word, frozen);
    hi_en_n = 0; #1;
    chk("R4 frozen bus", {8'd0, data_bus}, {8'd0, frozen[15:8]});
    hi_en_n = 1;
    hold_n = 1; @(negedge clk);
    chk("R4 release tracks", angle_word, exp_cnt);

    // R8 many up requests in one pulse: two steps in total
    @(negedge clk); up_req = 1;
    repeat (3) @(negedge clk);
    up_req = 0;
    repeat (2 * BUSY + 3) @(negedge clk);
    exp_cnt = exp_cnt + 16'd2;
    chk("R8 one queued up", angle_word, exp_cnt);

    // R9 simultaneous up and down: up first, then down
    @(negedge clk); up_req = 1; dn_req = 1;
    @(negedge clk); up_req = 0; dn_req = 0;
    chk("R9 up first", angle_word, exp_cnt + 16'd1);
    chk("R9 dir up first", {15'd0, dir_up}, 16'd1);
    repeat (BUSY + 2) @(negedge clk);
    chk("R9 down second", angle_word, exp_cnt);
    chk("R9 dir down last", {15'd0, dir_up}, 16'd0);
    repeat (BUSY + 2) @(negedge clk);
    chk("R7 dir held idle", {15'd0, dir_up}, 16'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule